// File: doc/BRIEF.md
# Acquisition Cycle Trigger Controller

This block decides the cycle in which a multi-channel measurement engine may begin an acquisition pass. The engine is seen only through a handshake: the controller emits a one-clock `start_cycle` pulse, and the engine answers with a one-clock `cycle_done` pulse when its pass is over. Between those two pulses the engine is busy, and the controller never issues a new start.

There are three trigger policies, chosen by a configuration byte. Timed mode paces starts from a programmable period that is measured from one start to the next. A period of zero gives free run, where each start follows the previous pass with no gap. The two synchronized modes follow an external sync pin. That pin first goes through a two-flop synchronizer and then a minimum-low-time filter. In level mode, passes repeat for as long as the filtered pin is low. In edge mode, every filtered rising edge requests exactly one pass. If a pass overruns its period in timed mode, the late start is flagged.

Top module: `acq_trig_ctrl`

## Requirements
- R1: While `rst_n` is low, `start_cycle` and `overrun` are 0. Internal reset is released through two clock stages. In timed mode with an idle engine, the first `start_cycle` therefore appears in the third cycle after the cycle in which `rst_n` rises.
- R2: `start_cycle` is high for one clock at a time. It is never high while the engine is busy. The engine is busy from a `start_cycle` pulse until the matching `cycle_done` pulse, and `cycle_done` may share a cycle with the next start's decision but not with the start itself.
- R3: Setting `mode_cfg` bit 0 to 1 selects timed mode. If `cycle_done` arrives no later than `period`-1 cycles after a start, the next start comes exactly `period` cycles after the previous one, and `overrun` stays 0.
- R4: In timed mode with `period` nonzero, suppose `cycle_done` arrives D ≥ `period` cycles after a start. The next start then comes D+1 cycles after the previous one, and `overrun` is high in the same cycle as that start and in no other cycle.
- R5: In timed mode with `period` equal to 0, each start comes one cycle after `cycle_done`, and `overrun` never asserts.
- R6: In timed mode the sync pin has no effect on when starts occur.
- R7: With bit 0 clear and bit 4 clear (level mode), passes run back to back while the filtered pin is low, each start one cycle after `cycle_done`. After the pin falls in cycle c from an idle state, the first start appears in cycle c+MIN_LOW_TICKS+3.
- R8: In level mode, once the pin is high, the pass in progress still completes. No new start occurs when `cycle_done` arrives three or more cycles after the pin rose, and none occurs while the pin stays high.
- R9: A low level on the sync pin is recognized only after MIN_LOW_TICKS consecutive low clocks. A low of MIN_LOW_TICKS-1 clocks causes no start in either synchronized mode.
- R10: With bit 0 clear and bit 4 set (edge mode), a rising edge after a recognized low yields exactly one start, 5 cycles after the cycle in which the pin rose. Holding the pin high gives no further starts.
- R11: In edge mode, edges that arrive while the engine is busy are merged into one pending request. That request starts a single pass one cycle after `cycle_done`, and any further edges in the same pass are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 8 | Bit 0: timed enable; bit 4: sync method (0 level, 1 edge) |
| period | input | PERIOD_W | Start-to-start period in clocks; 0 means free run |
| sync_in | input | 1 | External sync pin, asynchronous |
| cycle_done | input | 1 | One-clock pulse from the engine at the end of a pass |
| start_cycle | output | 1 | One-clock pulse that begins a pass |
| overrun | output | 1 | Pulses with a timed start that came late because the previous pass overran |

## Verification
The bench builds the block with PERIOD_W=8 and MIN_LOW_TICKS=8, so the filter's threshold can be hit exactly: seven low clocks are rejected and eight are accepted, all within a few dozen cycles. Periods from 0 to 20 against engine pass lengths from 1 to 20 cover both sides of the overrun boundary, including a pass that ends at period-1 versus one that ends at period. A 60-clock pass leaves room for three sync edges to arrive while the engine is busy.

// File: rtl/acq_trig_pkg.sv
`timescale 1ns/1ps
package acq_trig_pkg;

  localparam int CFG_W        = 8;
  localparam int CFG_TIMED_IX = 0;
  localparam int CFG_EDGE_IX  = 4;

  typedef enum logic [1:0] {
    TRIG_TIMED      = 2'd0,
    TRIG_SYNC_LEVEL = 2'd1,
    TRIG_SYNC_EDGE  = 2'd2
  } trig_mode_e;

  function automatic trig_mode_e decode_mode(input logic [CFG_W-1:0] cfg);
    trig_mode_e m;
    if (cfg[CFG_TIMED_IX])     m = TRIG_TIMED;
    else if (cfg[CFG_EDGE_IX]) m = TRIG_SYNC_EDGE;
    else                       m = TRIG_SYNC_LEVEL;
    return m;
  endfunction

endpackage

// File: rtl/acq_trig_rst_sync.sv
`timescale 1ns/1ps
module acq_trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/acq_trig_sync_filter.sv
`timescale 1ns/1ps
module acq_trig_sync_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_LOW_TICKS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_low_o,
  output logic rise_o
);

  localparam int CNT_W = $clog2(MIN_LOW_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_LOW_TICKS - 1);

  logic [SYNC_STAGES-1:0] meta_q, meta_d;
  logic                   pin_s;
  logic [CNT_W-1:0]       low_cnt_q, low_cnt_d;
  logic                   low_cnt_en;
  logic                   filt_hi_q, filt_hi_d;
  logic                   rise_q, rise_d;

  // synchronizer chain, idle value is high
  always_comb begin
    meta_d = {meta_q[SYNC_STAGES-2:0], pin_i};
    pin_s  = meta_q[SYNC_STAGES-1];
  end

  // low-time qualification
  always_comb begin
    if (pin_s) begin
      low_cnt_d  = '0;
      low_cnt_en = (low_cnt_q != '0);
    end else begin
      low_cnt_d  = low_cnt_q + 1'b1;
      low_cnt_en = (low_cnt_q != LAST_CNT);
    end

    if (pin_s)                       filt_hi_d = 1'b1;
    else if (low_cnt_q == LAST_CNT)  filt_hi_d = 1'b0;
    else                             filt_hi_d = filt_hi_q;

    rise_d = pin_s & ~filt_hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '1;
      low_cnt_q <= '0;
      filt_hi_q <= 1'b1;
      rise_q    <= 1'b0;
    end else begin
      meta_q    <= meta_d;
      if (low_cnt_en) low_cnt_q <= low_cnt_d;
      filt_hi_q <= filt_hi_d;
      rise_q    <= rise_d;
    end
  end

  assign level_low_o = ~filt_hi_q;
  assign rise_o      = rise_q;

endmodule

// File: rtl/acq_trig_period_timer.sv
`timescale 1ns/1ps
module acq_trig_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                due_o
);

  localparam logic [PERIOD_W-1:0] SAT = '1;

  logic [PERIOD_W-1:0] elapsed_q, elapsed_d;
  logic                elapsed_en;

  always_comb begin
    elapsed_d  = restart_i ? '0 : (elapsed_q + 1'b1);
    elapsed_en = restart_i | (elapsed_q != SAT);
    due_o      = (period_i == '0) || (elapsed_q >= (period_i - 1'b1));
  end

  // saturated after reset so the first timed pass starts at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          elapsed_q <= SAT;
    else if (elapsed_en) elapsed_q <= elapsed_d;
  end

endmodule

// File: rtl/acq_trig_sequencer.sv
`timescale 1ns/1ps
module acq_trig_sequencer
  import acq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode_i,
  input  logic       due_i,
  input  logic       period_nz_i,
  input  logic       level_low_i,
  input  logic       rise_i,
  input  logic       cycle_done_i,
  output logic       fire_o,
  output logic       start_o,
  output logic       overrun_o
);

  logic busy_q, busy_d;
  logic pend_q, pend_d;
  logic late_q, late_d;
  logic start_q, ovr_q, ovr_d;
  logic engine_free;
  logic want;

  always_comb begin
    engine_free = ~busy_q | cycle_done_i;

    unique case (mode_i)
      TRIG_TIMED:      want = due_i;
      TRIG_SYNC_LEVEL: want = level_low_i;
      TRIG_SYNC_EDGE:  want = pend_q;
      default:         want = 1'b0;
    endcase

    fire_o = want & engine_free;

    if (fire_o)            busy_d = 1'b1;
    else if (cycle_done_i) busy_d = 1'b0;
    else                   busy_d = busy_q;

    if (mode_i == TRIG_SYNC_EDGE) pend_d = (pend_q & ~fire_o) | rise_i;
    else                          pend_d = 1'b0;

    if ((mode_i != TRIG_TIMED) || fire_o) late_d = 1'b0;
    else late_d = late_q | (due_i & ~engine_free & period_nz_i);

    ovr_d = fire_o & late_q & period_nz_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      late_q  <= 1'b0;
      start_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      pend_q  <= pend_d;
      late_q  <= late_d;
      start_q <= fire_o;
      ovr_q   <= ovr_d;
    end
  end

  assign start_o   = start_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/acq_trig_ctrl.sv
`timescale 1ns/1ps
module acq_trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int PERIOD_W      = 16,
  parameter int MIN_LOW_TICKS = 125000,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    mode_cfg,
  input  logic [PERIOD_W-1:0] period,
  input  logic                sync_in,
  input  logic                cycle_done,
  output logic                start_cycle,
  output logic                overrun
);

  logic       srst_n;
  logic       lvl_low, rise;
  logic       due, fire;
  logic       period_nz;
  trig_mode_e mode;

  assign mode      = decode_mode(mode_cfg);
  assign period_nz = |period;

  acq_trig_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  acq_trig_sync_filter #(
    .SYNC_STAGES   (SYNC_STAGES),
    .MIN_LOW_TICKS (MIN_LOW_TICKS)
  ) filt_i (
    .clk         (clk),
    .rst_n       (srst_n),
    .pin_i       (sync_in),
    .level_low_o (lvl_low),
    .rise_o      (rise)
  );

  acq_trig_period_timer #(.PERIOD_W(PERIOD_W)) timer_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .restart_i (fire),
    .period_i  (period),
    .due_o     (due)
  );

  acq_trig_sequencer seq_i (
    .clk          (clk),
    .rst_n        (srst_n),
    .mode_i       (mode),
    .due_i        (due),
    .period_nz_i  (period_nz),
    .level_low_i  (lvl_low),
    .rise_i       (rise),
    .cycle_done_i (cycle_done),
    .fire_o       (fire),
    .start_o      (start_cycle),
    .overrun_o    (overrun)
  );

endmodule

// File: rtl/acq_trig_ctrl_chk.sv
`timescale 1ns/1ps
module acq_trig_ctrl_chk #(
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          mode_cfg,
  input logic [PERIOD_W-1:0] period,
  input logic                sync_in,
  input logic                cycle_done,
  input logic                start_cycle,
  input logic                overrun
);

  logic       eng_busy;
  logic [2:0] hi_run;
  logic       lvl_mode;

  assign lvl_mode = ~mode_cfg[0] & ~mode_cfg[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 1'b0;
      hi_run   <= '0;
    end else begin
      if (start_cycle)     eng_busy <= 1'b1;
      else if (cycle_done) eng_busy <= 1'b0;
      if (!sync_in)              hi_run <= '0;
      else if (hi_run != 3'd7)   hi_run <= hi_run + 3'd1;
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_cycle |=> !start_cycle);

  a_r2_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
    start_cycle |-> !eng_busy);

  a_r4_overrun_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> start_cycle);

  a_r5_free_run_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cfg[0] && period == '0 && $stable(period)) |-> !overrun);

  a_r8_high_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && $stable(mode_cfg) && hi_run >= 3'd4) |-> !start_cycle);

endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk #(.PERIOD_W(PERIOD_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_cfg    (mode_cfg),
  .period      (period),
  .sync_in     (sync_in),
  .cycle_done  (cycle_done),
  .start_cycle (start_cycle),
  .overrun     (overrun)
);

// File: tb/acq_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module acq_trig_ctrl_tb_top;

  localparam int PW    = 8;
  localparam int MINLO = 8;
  localparam int LOG_N = 1024;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    mode_cfg;
  logic [PW-1:0] period;
  logic          sync_in;
  logic          cycle_done = 1'b0;
  logic          start_cycle, overrun;

  int n_chk = 0, n_err = 0;
  int cyc = 0, rem = 0, eng_d = 3;
  int log_n = 0, n_done = 0, n_dbl = 0, n_busy = 0, n_stray = 0;
  int log_t [LOG_N];
  bit log_o [LOG_N];
  bit prev_start = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  acq_trig_ctrl #(.PERIOD_W(PW), .MIN_LOW_TICKS(MINLO)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .period(period),
    .sync_in(sync_in), .cycle_done(cycle_done),
    .start_cycle(start_cycle), .overrun(overrun)
  );

  // engine model and start log, evaluated at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      rem = 0; cycle_done = 1'b0; prev_start = 1'b0;
    end else begin
      if (start_cycle && prev_start) n_dbl++;
      if (start_cycle && rem > 0) n_busy++;
      if (overrun && !start_cycle) n_stray++;
      if (start_cycle) begin
        log_t[log_n % LOG_N] = cyc;
        log_o[log_n % LOG_N] = overrun;
        log_n++;
        rem = eng_d;
        cycle_done = 1'b0;
      end else if (rem > 0) begin
        rem--;
        cycle_done = (rem == 0);
        if (rem == 0) n_done++;
      end else begin
        cycle_done = 1'b0;
      end
      prev_start = start_cycle;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_count(input int base, input int n, input int limit, input bit toggle);
    for (int i = 0; i < limit && (log_n - base) < n; i++) begin
      step();
      if (toggle) sync_in = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic pulse_low(input int k);
    sync_in = 1'b0;
    for (int i = 0; i < k; i++) step();
    sync_in = 1'b1;
  endtask

  function automatic int t_at(input int i);
    return log_t[i % LOG_N];
  endfunction

  function automatic int exp_gap(input int p, input int d);
    return (p > d + 1) ? p : d + 1;
  endfunction

  function automatic int exp_ovr(input int p, input int d);
    return (p != 0 && d >= p) ? 1 : 0;
  endfunction

  task automatic run_timed(input int p, input int d, input bit toggle);
    int base;
    string rq;
    step();
    mode_cfg = 8'h01;
    period   = PW'(p);
    eng_d    = d;
    base     = log_n;
    wait_count(base, 5, 600, toggle);
    rq = toggle ? "R6" : ((p == 0) ? "R5" : (exp_ovr(p, d) != 0 ? "R4" : "R3"));
    check(rq, log_n - base >= 5 ? 1 : 0, 1, "five timed starts seen");
    for (int k = 1; k < 5; k++) begin
      check(rq, t_at(base + k) - t_at(base + k - 1), exp_gap(p, d), "start gap");
      check(rq, int'(log_o[(base + k) % LOG_N]), exp_ovr(p, d), "overrun flag");
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    int base, c, h, nd, b2, p, d;
    void'($urandom(32'h2468ACE1));
    rst_n = 1'b0; mode_cfg = 8'h01; period = PW'(4); sync_in = 1'b1; eng_d = 2;

    // R1: reset holds outputs low although timed mode would fire
    for (int i = 0; i < 5; i++) begin
      step();
      check("R1", {31'd0, start_cycle}, 0, "start_cycle in reset");
      check("R1", {31'd0, overrun}, 0, "overrun in reset");
    end
    base = log_n;
    rst_n = 1'b1;
    c = cyc;
    wait_count(base, 2, 50, 1'b0);
    check("R1", t_at(base) - c, 3, "first start after release");
    check("R3", t_at(base + 1) - t_at(base), 4, "gap after reset");

    // directed timed corners
    run_timed(10, 3, 1'b0);
    run_timed(10, 9, 1'b0);
    run_timed(10, 10, 1'b0);
    run_timed(0, 4, 1'b0);
    run_timed(1, 1, 1'b0);
    run_timed(5, 20, 1'b0);
    run_timed(0, 1, 1'b0);

    // constrained random timed runs with sync toggling (R6)
    for (int it = 0; it < 20; it++) begin
      p = $urandom_range(0, 20);
      d = $urandom_range(1, 20);
      run_timed(p, d, it[0]);
    end
    sync_in = 1'b1;

    // level mode
    step(); mode_cfg = 8'h00; eng_d = 3;
    idle(80);
    base = log_n;
    idle(40);
    check("R8", log_n - base, 0, "no start while pin high");
    step(); pulse_low(MINLO - 1);
    idle(30);
    check("R9", log_n - base, 0, "short low rejected in level mode");
    step(); c = cyc; sync_in = 1'b0; base = log_n;
    wait_count(base, 4, 200, 1'b0);
    check("R7", t_at(base) - c, MINLO + 3, "first level start latency");
    for (int k = 1; k < 4; k++)
      check("R7", t_at(base + k) - t_at(base + k - 1), 4, "back-to-back gap");
    b2 = log_n;
    while (log_n == b2) step();
    sync_in = 1'b1; nd = n_done; b2 = log_n;
    idle(40);
    check("R8", log_n - b2, 0, "no start after pin rose");
    check("R8", n_done - nd, 1, "pass in progress completed");

    // edge mode
    step(); mode_cfg = 8'h10; eng_d = 5;
    base = log_n;
    idle(20);
    check("R10", log_n - base, 0, "steady high gives no start");
    step(); pulse_low(MINLO - 1);
    idle(30);
    check("R9", log_n - base, 0, "short low rejected in edge mode");
    step(); pulse_low(MINLO); h = cyc; base = log_n;
    idle(30);
    check("R10", log_n - base, 1, "one start per edge");
    check("R10", t_at(base) - h, 5, "edge start latency");
    idle(20);
    check("R10", log_n - base, 1, "held high adds nothing");

    step(); eng_d = 60; base = log_n;
    for (int e = 0; e < 3; e++) begin
      pulse_low(10);
      idle(2);
    end
    idle(150);
    check("R11", log_n - base, 2, "edges during busy merged");
    check("R11", t_at(base + 1) - t_at(base), 61, "pending served after done");

    check("R2", n_dbl, 0, "start pulses longer than one clock");
    check("R2", n_busy, 0, "start while engine busy");
    check("R4", n_stray, 0, "overrun without start");

    finished = 1'b1;
    finish_run();
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

endmodule